// File: doc/BRIEF.md
# Receive Interrupt Coalescing Controller

This block sits between a receive engine and an interrupt controller. It turns a stream of per-frame completion pulses into fewer interrupt requests. In coalescing mode, the block counts received frames. It also runs a slow timer that starts with the first frame of a window. The request is raised on whichever threshold is met first: the frame-count threshold or the timer threshold. The timer advances once for every 64 ticks of a selectable tick source. The source is either a receive-interface tick enable or a system tick enable, and both are qualifiers within the single clock domain of the block.

A settings register is loaded through a plain write strobe and resets to all zeros, so the block comes out of reset in pass-through mode. In pass-through mode every frame pulse raises the request on the next edge. A separate mask input gates every request. The request output is sticky and is cleared by a one-cycle acknowledge pulse. All pins are plain control and status signals. No data flows through the block, so no valid/ready handshake applies.

Top module: `rx_coalesce_ctrl`

## Requirements
- R1: After reset the settings register holds zero (coalescing off, select 0, both thresholds 0) and `irq` is low.
- R2: In pass-through mode (`cfg_en`=0) with `rxf_mask`=1, a sampled `frame_pulse` makes `irq` high after that same clock edge.
- R3: With `rxf_mask`=0, `irq` never rises in either mode. In coalescing mode the frames are still counted, so setting the mask later raises `irq` on the next edge if the count has already reached the frame threshold.
- R4: In coalescing mode, `irq` rises after the edge that samples the frame bringing the window's frame count up to `cfg_frame_thr`.
- R5: In coalescing mode, `irq` rises after the edge on which the coalescing timer reaches `cfg_time_thr`, even with fewer frames than the frame threshold.
- R6: The timer advances once per 64 sampled tick enables. The tick source is `tick_rx` when `cfg_clk_sel`=0 and `tick_sys` when `cfg_clk_sel`=1; the unselected tick has no effect.
- R7: The timer and its prescaler stay at zero while no frame is pending. They start counting on the edge after the first frame of a window.
- R8: When the request is raised, the frame count, the timer and the prescaler all return to zero.
- R9: `irq` stays high until `irq_ack` is sampled high. A new request in the same cycle as an acknowledge leaves `irq` high.
- R10: A threshold of zero disables its condition. With both thresholds zero and `cfg_en`=1, the block behaves as in pass-through mode.
- R11: A frame sampled in the same cycle as `irq_ack` counts toward the next window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Loads the settings register from the cfg_* inputs |
| cfg_en | input | 1 | Coalescing enable (0 = pass-through) |
| cfg_clk_sel | input | 1 | Timer tick source: 0 = tick_rx, 1 = tick_sys |
| cfg_frame_thr | input | 8 | Frame-count threshold (0 = off) |
| cfg_time_thr | input | 16 | Timer threshold in 64-tick units (0 = off) |
| rxf_mask | input | 1 | Receive-frame interrupt mask, 1 = enabled |
| frame_pulse | input | 1 | One-cycle pulse per received frame |
| tick_rx | input | 1 | Receive-interface tick enable |
| tick_sys | input | 1 | System tick enable |
| irq_ack | input | 1 | Write-one acknowledge of the request |
| irq | output | 1 | Sticky interrupt request |

## Verification
A wrong frame count shows up at `irq` on the first frame that should, or should not, reach the threshold. That is at most one frame pulse after the fault. A prescaler or timer fault shows up only after a full 64-tick period, so the timer checks sample `irq` on the exact edge before and the exact edge of the expected fire. Stale counts that were not cleared after a fire show up one window later, as an early request. For that reason the bench checks the window that follows every timer fire.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
  typedef enum logic {
    SRC_RX  = 1'b0,
    SRC_SYS = 1'b1
  } tick_src_e;

  typedef enum logic {
    MODE_PASS     = 1'b0,
    MODE_COALESCE = 1'b1
  } coal_mode_e;
endpackage

// File: rtl/rxc_cfg_reg.sv
module rxc_cfg_reg
  import rxc_pkg::*;
#(
  parameter int FCNT_W = 8,
  parameter int TCNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              en_in,
  input  logic              sel_in,
  input  logic [FCNT_W-1:0] fthr_in,
  input  logic [TCNT_W-1:0] tthr_in,
  output tick_src_e         src,
  output coal_mode_e        mode,
  output logic [FCNT_W-1:0] fthr,
  output logic [TCNT_W-1:0] tthr
);
  logic en_q;
  logic sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= 1'b0;
      fthr  <= '0;
      tthr  <= '0;
    end else if (we) begin
      en_q  <= en_in;
      sel_q <= sel_in;
      fthr  <= fthr_in;
      tthr  <= tthr_in;
    end
  end

  // both thresholds off degrades coalescing to pass-through
  always_comb begin
    src  = sel_q ? SRC_SYS : SRC_RX;
    mode = (en_q && ((fthr != '0) || (tthr != '0))) ? MODE_COALESCE : MODE_PASS;
  end
endmodule

// File: rtl/rxc_prescaler.sv
module rxc_prescaler
  import rxc_pkg::*;
#(
  parameter int DIV = 64
) (
  input  logic      clk,
  input  logic      rst_n,
  input  tick_src_e src,
  input  logic      tick_rx,
  input  logic      tick_sys,
  input  logic      run,
  input  logic      clr,
  output logic      step,
  output logic      idle
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] cnt_q;
  logic          adv;

  always_comb begin
    adv  = run && ((src == SRC_SYS) ? tick_sys : tick_rx);
    step = adv && (cnt_q == LAST);
    idle = (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (step) cnt_q <= '0;
    else if (adv)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rxc_sat_counter.sv
module rxc_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] val,
  output logic [W-1:0] peek
);
  always_comb begin
    if (val == '1) peek = val;
    else           peek = val + {{(W-1){1'b0}}, inc};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   val <= '0;
    else if (clr) val <= '0;
    else          val <= peek;
  end
endmodule

// File: rtl/rx_coalesce_ctrl.sv
module rx_coalesce_ctrl
  import rxc_pkg::*;
#(
  parameter int FCNT_W = 8,
  parameter int TCNT_W = 16,
  parameter int PRESC_DIV = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_en,
  input  logic              cfg_clk_sel,
  input  logic [FCNT_W-1:0] cfg_frame_thr,
  input  logic [TCNT_W-1:0] cfg_time_thr,
  input  logic              rxf_mask,
  input  logic              frame_pulse,
  input  logic              tick_rx,
  input  logic              tick_sys,
  input  logic              irq_ack,
  output logic              irq
);
  tick_src_e         src;
  coal_mode_e        mode;
  logic [FCNT_W-1:0] fthr;
  logic [TCNT_W-1:0] tthr;
  logic [FCNT_W-1:0] fcnt, fcnt_peek;
  logic [TCNT_W-1:0] tcnt, tcnt_peek;
  logic              tstep, pre_idle;
  logic              pass, pending, hit_f, hit_t, fire, wipe;

  rxc_cfg_reg #(.FCNT_W(FCNT_W), .TCNT_W(TCNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we),
    .en_in(cfg_en), .sel_in(cfg_clk_sel),
    .fthr_in(cfg_frame_thr), .tthr_in(cfg_time_thr),
    .src(src), .mode(mode), .fthr(fthr), .tthr(tthr)
  );

  always_comb begin
    pass    = (mode == MODE_PASS);
    pending = (fcnt != '0);
    hit_f   = (fthr != '0) && (fcnt_peek >= fthr);
    hit_t   = (tthr != '0) && (tcnt_peek >= tthr);
    fire    = rxf_mask && (pass ? frame_pulse : (hit_f || hit_t));
    wipe    = pass || fire;
  end

  rxc_sat_counter #(.W(FCNT_W)) u_frames (
    .clk(clk), .rst_n(rst_n), .inc(frame_pulse), .clr(wipe),
    .val(fcnt), .peek(fcnt_peek)
  );

  rxc_prescaler #(.DIV(PRESC_DIV)) u_presc (
    .clk(clk), .rst_n(rst_n), .src(src), .tick_rx(tick_rx),
    .tick_sys(tick_sys), .run(pending), .clr(wipe),
    .step(tstep), .idle(pre_idle)
  );

  rxc_sat_counter #(.W(TCNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .inc(tstep), .clr(wipe),
    .val(tcnt), .peek(tcnt_peek)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq <= 1'b0;
    else if (fire)    irq <= 1'b1;
    else if (irq_ack) irq <= 1'b0;
  end

  // R2
  pass_frame_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pass && frame_pulse && rxf_mask) |=> irq);

  // R3
  masked_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(rxf_mask));

  // R7
  idle_timer_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fcnt == '0) |-> ((tcnt == '0) && pre_idle));

  // R8
  fire_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ((fcnt == '0) && (tcnt == '0) && pre_idle));

  // R9
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq);
endmodule

// File: tb/rx_coalesce_ctrl_tb.sv
module rx_coalesce_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_en = 1'b0, cfg_clk_sel = 1'b0;
  logic [7:0]  cfg_frame_thr = '0;
  logic [15:0] cfg_time_thr = '0;
  logic rxf_mask = 1'b0, frame_pulse = 1'b0, tick_rx = 1'b0, tick_sys = 1'b0, irq_ack = 1'b0;
  logic irq;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rx_coalesce_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_en(cfg_en),
    .cfg_clk_sel(cfg_clk_sel), .cfg_frame_thr(cfg_frame_thr),
    .cfg_time_thr(cfg_time_thr), .rxf_mask(rxf_mask),
    .frame_pulse(frame_pulse), .tick_rx(tick_rx), .tick_sys(tick_sys),
    .irq_ack(irq_ack), .irq(irq)
  );

  // {en, sel, frame_thr[8], time_thr[16], mask, n_frames[8], expected irq}
  localparam logic [35:0] VEC [9] = '{
    {1'b0, 1'b0, 8'd0,   16'd0, 1'b1, 8'd1,  1'b1},  // R2
    {1'b0, 1'b0, 8'd0,   16'd0, 1'b0, 8'd3,  1'b0},  // R3
    {1'b1, 1'b0, 8'd4,   16'd0, 1'b1, 8'd3,  1'b0},  // R4
    {1'b1, 1'b0, 8'd4,   16'd0, 1'b1, 8'd4,  1'b1},  // R4
    {1'b1, 1'b0, 8'd4,   16'd0, 1'b0, 8'd6,  1'b0},  // R3
    {1'b1, 1'b0, 8'd0,   16'd0, 1'b1, 8'd1,  1'b1},  // R10
    {1'b1, 1'b0, 8'd1,   16'd0, 1'b1, 8'd1,  1'b1},  // R4
    {1'b1, 1'b0, 8'd255, 16'd0, 1'b1, 8'd10, 1'b0},  // R4
    {1'b1, 1'b1, 8'd0,   16'd5, 1'b1, 8'd20, 1'b0}   // R10
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s irq=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    frame_pulse = 1'b0; irq_ack = 1'b0; tick_rx = 1'b0; tick_sys = 1'b0; cfg_we = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic write_cfg(input logic en, input logic sel, input logic [7:0] ft, input logic [15:0] tt);
    cfg_en = en; cfg_clk_sel = sel; cfg_frame_thr = ft; cfg_time_thr = tt;
    cfg_we = 1'b1;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic frames(input int n);
    for (int k = 0; k < n; k++) begin
      frame_pulse = 1'b1;
      step();
      frame_pulse = 1'b0;
    end
  endtask

  task automatic ack();
    irq_ack = 1'b1;
    step();
    irq_ack = 1'b0;
  endtask

  initial begin
    #1;
    // R1: reset state, then default config acts as pass-through
    do_reset();
    chk("R1 irq low after reset", irq, 1'b0);
    rxf_mask = 1'b1;
    frames(1);
    chk("R1 settings zero -> pass-through", irq, 1'b1);

    for (int i = 0; i < 9; i++) begin
      do_reset();
      write_cfg(VEC[i][35], VEC[i][34], VEC[i][33:26], VEC[i][25:10]);
      rxf_mask = VEC[i][9];
      frames(int'(VEC[i][8:1]));
      chk($sformatf("R2/R3/R4/R10 vector %0d", i), irq, VEC[i][0]);
    end

    // R3: masked frames are counted; setting the mask fires at once
    do_reset();
    write_cfg(1'b1, 1'b0, 8'd3, 16'd0);
    rxf_mask = 1'b0;
    frames(4);
    chk("R3 masked no irq", irq, 1'b0);
    rxf_mask = 1'b1;
    step();
    chk("R3 unmask with count reached", irq, 1'b1);

    // R5 R6: system tick source, time threshold 2 -> 128 ticks
    do_reset();
    write_cfg(1'b1, 1'b1, 8'd3, 16'd2);
    rxf_mask = 1'b1;
    tick_sys = 1'b1;
    frames(1);
    for (int k = 0; k < 127; k++) step();
    chk("R5 one edge before timer fire", irq, 1'b0);
    step();
    chk("R5 R6 timer fire at 128 ticks", irq, 1'b1);
    // R9: sticky until ack
    for (int k = 0; k < 5; k++) step();
    chk("R9 irq held", irq, 1'b1);
    tick_sys = 1'b0;
    ack();
    chk("R9 ack clears", irq, 1'b0);
    // R8: count cleared by fire, so two frames are not enough for threshold 3
    frames(2);
    chk("R8 counter cleared on fire", irq, 1'b0);
    frames(1);
    chk("R8 fresh window reaches 3", irq, 1'b1);

    // R6: receive tick source ignores system ticks
    do_reset();
    write_cfg(1'b1, 1'b0, 8'd50, 16'd2);
    rxf_mask = 1'b1;
    tick_sys = 1'b1;
    frames(1);
    for (int k = 0; k < 300; k++) step();
    chk("R6 unselected tick has no effect", irq, 1'b0);
    tick_sys = 1'b0;
    tick_rx = 1'b1;
    for (int k = 0; k < 127; k++) step();
    chk("R6 rx tick one before fire", irq, 1'b0);
    step();
    chk("R6 rx tick fire at 128", irq, 1'b1);
    tick_rx = 1'b0;

    // R7: timer idle until first frame
    do_reset();
    write_cfg(1'b1, 1'b1, 8'd0, 16'd1);
    rxf_mask = 1'b1;
    tick_sys = 1'b1;
    for (int k = 0; k < 200; k++) step();
    chk("R7 no frame no timer", irq, 1'b0);
    frames(1);
    for (int k = 0; k < 63; k++) step();
    chk("R7 timer starts after frame (63)", irq, 1'b0);
    step();
    chk("R7 timer fire at 64", irq, 1'b1);
    tick_sys = 1'b0;

    // R11: frame with ack counts toward next window
    do_reset();
    write_cfg(1'b1, 1'b0, 8'd2, 16'd0);
    rxf_mask = 1'b1;
    frames(2);
    chk("R4 two frames fire", irq, 1'b1);
    irq_ack = 1'b1;
    frame_pulse = 1'b1;
    step();
    irq_ack = 1'b0;
    frame_pulse = 1'b0;
    chk("R11 ack with frame clears irq", irq, 1'b0);
    frames(1);
    chk("R11 frame with ack was counted", irq, 1'b1);

    // R9: new request with ack keeps irq high (pass-through)
    write_cfg(1'b0, 1'b0, 8'd0, 16'd0);
    irq_ack = 1'b1;
    frame_pulse = 1'b1;
    step();
    irq_ack = 1'b0;
    frame_pulse = 1'b0;
    chk("R9 set wins over ack", irq, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule